// File: doc/BRIEF.md
# Anger-logic position and energy qualifier

This block turns one trigger from a four-channel light-sharing scintillation detector into a single-event record. The four digitized channel amplitudes (called A, B, C and D here) are summed into a total energy. Two normalized position ratios are formed from them: Y as (A+B)/E and X as (B+D)/E. Each ratio is computed to a fixed number of fractional bits by a pipelined restoring divider.

The ratios are then cut down to a few bits each and concatenated into the address of a crystal map table, whose entry is the crystal identifier. A second table, indexed by that identifier, holds an inclusive low/high energy window for each crystal. The event is marked accepted only when its energy lies inside its crystal's window.

Every event leaves the block as a record carrying the crystal, the energy and the accept flag, including events that are rejected. The flow uses a ready/valid handshake. Backpressure freezes the whole pipeline, so the latency is fixed. Both tables are written through dedicated write ports while no events are in flight.

Top module: `anger_event_qualifier`

## Requirements
- R1: `out_energy` equals A+B+C+D, zero-extended to CH_W+2 bits.
- R2: The Y ratio is floor((A+B)·2^FRAC_W/E) and the X ratio is floor((B+D)·2^FRAC_W/E). Each is quantized to its top Q_W fractional bits, ratio >> (FRAC_W-Q_W). A ratio equal to 1.0 saturates to all ones (2^Q_W-1).
- R3: `out_crystal` is the crystal map entry at address {Y index, X index}, with the Y index in the upper Q_W bits. An entry is written by `map_we` with `map_addr`/`map_id`.
- R4: `out_accept` is 1 exactly when win_lo ≤ E ≤ win_hi, both bounds inclusive. The bounds are the ones written for `out_crystal` through `win_we`/`win_crystal`/`win_lo`/`win_hi`.
- R5: An event whose energy falls outside its window still produces a record, with `out_accept`=0.
- R6: An event with E=0 produces a record with `out_crystal`=0, `out_energy`=0 and `out_accept`=0.
- R7: With `out_ready` held high, `out_valid` for an event rises FRAC_W+5 clock edges after the edge that accepted it.
- R8: `in_ready` is high whenever `out_ready` is high or `out_valid` is low. With `out_ready` held high, one event is accepted on every clock.
- R9: While `out_valid` is high and `out_ready` is low, the output record holds stable. No event is lost, duplicated or reordered.
- R10: After a synchronous reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Channel sample set is valid |
| in_ready | output | 1 | Block accepts an event this cycle |
| in_a | input | CH_W | Channel A amplitude |
| in_b | input | CH_W | Channel B amplitude |
| in_c | input | CH_W | Channel C amplitude |
| in_d | input | CH_W | Channel D amplitude |
| out_valid | output | 1 | Event record is valid |
| out_ready | input | 1 | Downstream accepts the record |
| out_crystal | output | ID_W | Crystal identifier |
| out_energy | output | CH_W+2 | Total energy |
| out_accept | output | 1 | Energy inside the crystal window |
| map_we | input | 1 | Crystal map write strobe |
| map_addr | input | 2*Q_W | Crystal map address {Y index, X index} |
| map_id | input | ID_W | Crystal identifier to store |
| win_we | input | 1 | Window table write strobe |
| win_crystal | input | ID_W | Crystal whose window is written |
| win_lo | input | CH_W+2 | Inclusive lower energy bound |
| win_hi | input | CH_W+2 | Inclusive upper energy bound |

## Verification
The bench builds the block with CH_W=10, FRAC_W=8, Q_W=4 and ID_W=8. At these values the 256-entry crystal map and the 256-entry window table can both be loaded completely through the write ports. The quantizer also drops four fractional bits, so truncation and the 1.0 saturation case are both exercised. With a 12-bit energy, windows can be placed exactly on a chosen event's energy to probe both inclusive bounds, and random backpressure covers the frozen pipeline across all FRAC_W+5 stages.

// File: rtl/anger_pkg.sv
package anger_pkg;

    // Default geometry of the qualifier
    localparam int unsigned CH_W_DEF   = 12;
    localparam int unsigned FRAC_W_DEF = 8;
    localparam int unsigned Q_W_DEF    = 5;
    localparam int unsigned ID_W_DEF   = 8;

    // Quantize a ratio in [0, 1.0] held with fw fractional bits down to qw bits.
    // A ratio of exactly 1.0 saturates to the top code.
    function automatic int unsigned quant_ratio(input int unsigned r,
                                                input int unsigned fw,
                                                input int unsigned qw);
        if ((r >> fw) != 0)
            return (32'd1 << qw) - 32'd1;
        return r >> (fw - qw);
    endfunction

    // Inclusive energy window test
    function automatic logic in_window(input int unsigned e,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (e >= lo) && (e <= hi);
    endfunction

endpackage

// File: rtl/anger_ratio_div.sv
// Restoring divider, one quotient bit per pipeline stage.
// Requires num <= den; produces floor(num * 2^FRAC_W / den) in FRAC_W+1 bits.
module anger_ratio_div #(
    parameter int NUM_W  = 14,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic [NUM_W-1:0]  num,
    input  logic [NUM_W-1:0]  den,
    output logic [FRAC_W:0]   quo
);

    for (genvar k = 0; k <= FRAC_W; k++) begin : g_st
        logic [NUM_W:0]   trial;
        logic [NUM_W-1:0] den_in;
        logic             qbit;
        logic [k:0]       quo_q;

        if (k == 0) begin : g_src
            assign trial  = {1'b0, num};
            assign den_in = den;
            always_ff @(posedge clk) begin
                if (en) quo_q <= qbit;
            end
        end else begin : g_src
            assign trial  = {g_st[k-1].g_nxt.rem_q, 1'b0};
            assign den_in = g_st[k-1].g_nxt.den_q;
            always_ff @(posedge clk) begin
                if (en) quo_q <= {g_st[k-1].quo_q, qbit};
            end
        end

        assign qbit = (trial >= {1'b0, den_in});

        if (k < FRAC_W) begin : g_nxt
            logic [NUM_W-1:0] rem_q;
            logic [NUM_W-1:0] den_q;
            always_ff @(posedge clk) begin
                if (en) begin
                    rem_q <= qbit ? NUM_W'(trial - {1'b0, den_in}) : trial[NUM_W-1:0];
                    den_q <= den_in;
                end
            end
        end
    end

    assign quo = g_st[FRAC_W].quo_q;

endmodule

// File: rtl/anger_pipe_delay.sv
// Stallable delay line with synchronous reset.
module anger_pipe_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (en) begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];

endmodule

// File: rtl/anger_lut_ram.sv
// Simple dual-port table: one write port, one registered read port with enable.
module anger_lut_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/anger_event_qualifier.sv
module anger_event_qualifier
    import anger_pkg::*;
#(
    parameter int CH_W   = CH_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    parameter int Q_W    = Q_W_DEF,
    parameter int ID_W   = ID_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CH_W-1:0]     in_a,
    input  logic [CH_W-1:0]     in_b,
    input  logic [CH_W-1:0]     in_c,
    input  logic [CH_W-1:0]     in_d,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ID_W-1:0]     out_crystal,
    output logic [CH_W+1:0]     out_energy,
    output logic                out_accept,
    input  logic                map_we,
    input  logic [2*Q_W-1:0]    map_addr,
    input  logic [ID_W-1:0]     map_id,
    input  logic                win_we,
    input  logic [ID_W-1:0]     win_crystal,
    input  logic [CH_W+1:0]     win_lo,
    input  logic [CH_W+1:0]     win_hi
);

    localparam int E_W     = CH_W + 2;
    localparam int DIV_LAT = FRAC_W + 1;
    localparam int MAP_AW  = 2 * Q_W;
    localparam int SIDE_W  = E_W + 2;

    // Whole-pipeline advance: everything moves or everything holds
    logic adv;
    logic o_vld;
    assign adv      = out_ready | ~o_vld;
    assign in_ready = adv;

    // ---------------- Stage 0: sums ----------------
    logic           s0_vld;
    logic           s0_zero;
    logic [E_W-1:0] s0_e;
    logic [E_W-1:0] s0_ny;
    logic [E_W-1:0] s0_nx;
    logic [E_W-1:0] sum_e;

    assign sum_e = E_W'(in_a) + E_W'(in_b) + E_W'(in_c) + E_W'(in_d);

    always_ff @(posedge clk) begin
        if (rst)      s0_vld <= 1'b0;
        else if (adv) s0_vld <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            s0_e    <= sum_e;
            s0_zero <= (sum_e == '0);
            s0_ny   <= E_W'(in_a) + E_W'(in_b);
            s0_nx   <= E_W'(in_b) + E_W'(in_d);
        end
    end

    // ---------------- Ratio dividers ----------------
    logic [FRAC_W:0] y_ratio;
    logic [FRAC_W:0] x_ratio;

    anger_ratio_div #(.NUM_W(E_W), .FRAC_W(FRAC_W)) u_ydiv (
        .clk (clk), .en (adv), .num (s0_ny), .den (s0_e), .quo (y_ratio)
    );

    anger_ratio_div #(.NUM_W(E_W), .FRAC_W(FRAC_W)) u_xdiv (
        .clk (clk), .en (adv), .num (s0_nx), .den (s0_e), .quo (x_ratio)
    );

    logic [SIDE_W-1:0] dv_side;
    logic              dv_vld;
    logic              dv_zero;
    logic [E_W-1:0]    dv_e;

    anger_pipe_delay #(.W(SIDE_W), .DEPTH(DIV_LAT)) u_side (
        .clk (clk), .rst (rst), .en (adv),
        .d   ({s0_vld, s0_zero, s0_e}),
        .q   (dv_side)
    );

    assign {dv_vld, dv_zero, dv_e} = dv_side;

    // ---------------- Quantize and crystal map lookup ----------------
    logic [Q_W-1:0]    yq;
    logic [Q_W-1:0]    xq;
    logic [ID_W-1:0]   m_id;
    logic              s1_vld;
    logic              s1_zero;
    logic [E_W-1:0]    s1_e;

    assign yq = Q_W'(quant_ratio(32'(y_ratio), FRAC_W, Q_W));
    assign xq = Q_W'(quant_ratio(32'(x_ratio), FRAC_W, Q_W));

    anger_lut_ram #(.AW(MAP_AW), .DW(ID_W)) u_map (
        .clk (clk), .we (map_we), .waddr (map_addr), .wdata (map_id),
        .re  (adv), .raddr ({yq, xq}), .rdata (m_id)
    );

    always_ff @(posedge clk) begin
        if (rst)      s1_vld <= 1'b0;
        else if (adv) s1_vld <= dv_vld;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            s1_zero <= dv_zero;
            s1_e    <= dv_e;
        end
    end

    // ---------------- Window lookup ----------------
    logic [2*E_W-1:0]  w_bounds;
    logic              s2_vld;
    logic              s2_zero;
    logic [E_W-1:0]    s2_e;
    logic [ID_W-1:0]   s2_id;
    logic [E_W-1:0]    w_lo;
    logic [E_W-1:0]    w_hi;

    anger_lut_ram #(.AW(ID_W), .DW(2*E_W)) u_win (
        .clk (clk), .we (win_we), .waddr (win_crystal), .wdata ({win_hi, win_lo}),
        .re  (adv), .raddr (m_id), .rdata (w_bounds)
    );

    assign {w_hi, w_lo} = w_bounds;

    always_ff @(posedge clk) begin
        if (rst)      s2_vld <= 1'b0;
        else if (adv) s2_vld <= s1_vld;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            s2_zero <= s1_zero;
            s2_e    <= s1_e;
            s2_id   <= m_id;
        end
    end

    // ---------------- Output record ----------------
    logic [ID_W-1:0] o_id;
    logic [E_W-1:0]  o_e;
    logic            o_acc;

    always_ff @(posedge clk) begin
        if (rst)      o_vld <= 1'b0;
        else if (adv) o_vld <= s2_vld;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            o_id  <= s2_zero ? '0 : s2_id;
            o_e   <= s2_e;
            o_acc <= ~s2_zero & in_window(32'(s2_e), 32'(w_lo), 32'(w_hi));
        end
    end

    assign out_valid   = o_vld;
    assign out_crystal = o_id;
    assign out_energy  = o_e;
    assign out_accept  = o_acc;

    // ---------------- Assertions ----------------
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (o_vld && !out_ready) |=> (o_vld && $stable(o_id) && $stable(o_e) && $stable(o_acc)));

    assert_zero_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (o_vld && o_e == '0) |-> (!o_acc && o_id == '0));

    assert_reset_empty_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!o_vld && in_ready));

    assert_ratio_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (dv_vld && !dv_zero) |->
            ((y_ratio <= ((FRAC_W+1)'(1) << FRAC_W)) && (x_ratio <= ((FRAC_W+1)'(1) << FRAC_W))));

endmodule

// File: tb/anger_event_qualifier_tb_top.sv
module anger_event_qualifier_tb_top;

    localparam int CH_W   = 10;
    localparam int FRAC_W = 8;
    localparam int Q_W    = 4;
    localparam int ID_W   = 8;
    localparam int E_W    = CH_W + 2;
    localparam int LAT    = FRAC_W + 5;
    localparam int NMAP   = 1 << (2*Q_W);
    localparam int NWIN   = 1 << ID_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [CH_W-1:0]   in_a = '0, in_b = '0, in_c = '0, in_d = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [ID_W-1:0]   out_crystal;
    logic [E_W-1:0]    out_energy;
    logic              out_accept;
    logic              map_we = 1'b0;
    logic [2*Q_W-1:0]  map_addr = '0;
    logic [ID_W-1:0]   map_id = '0;
    logic              win_we = 1'b0;
    logic [ID_W-1:0]   win_crystal = '0;
    logic [E_W-1:0]    win_lo = '0, win_hi = '0;

    always #4 clk = ~clk;

    anger_event_qualifier #(.CH_W(CH_W), .FRAC_W(FRAC_W), .Q_W(Q_W), .ID_W(ID_W)) dut_i (
        .clk, .rst, .in_valid, .in_ready, .in_a, .in_b, .in_c, .in_d,
        .out_valid, .out_ready, .out_crystal, .out_energy, .out_accept,
        .map_we, .map_addr, .map_id, .win_we, .win_crystal, .win_lo, .win_hi
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    bit lat_on = 0;
    bit took   = 0;

    int map_m [NMAP];
    int lo_m  [NWIN];
    int hi_m  [NWIN];

    int q_id[$], q_e[$], q_acc[$], q_cyc[$];

    bit        hold_pend = 0;
    int        h_id, h_e, h_acc;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic void model(input int a, b, c, d, output int id, output int e, output int acc);
        int yr, xr, yq, xq;
        e = a + b + c + d;
        if (e == 0) begin
            id = 0; acc = 0;
            return;
        end
        yr = ((a + b) << FRAC_W) / e;
        xr = ((b + d) << FRAC_W) / e;
        yq = (yr >= (1 << FRAC_W)) ? (1 << Q_W) - 1 : yr >> (FRAC_W - Q_W);
        xq = (xr >= (1 << FRAC_W)) ? (1 << Q_W) - 1 : xr >> (FRAC_W - Q_W);
        id  = map_m[yq * (1 << Q_W) + xq];
        acc = (e >= lo_m[id] && e <= hi_m[id]) ? 1 : 0;
    endfunction

    task automatic tick(input bit v, input int a, b, c, d, input bit rdy);
        int id, e, acc;
        @(negedge clk);
        in_valid  = v;
        in_a      = CH_W'(a);
        in_b      = CH_W'(b);
        in_c      = CH_W'(c);
        in_d      = CH_W'(d);
        out_ready = rdy;
        #1;
        cyc++;
        if (hold_pend) begin
            chk(out_valid && int'(out_crystal) == h_id && int'(out_energy) == h_e && int'(out_accept) == h_acc,
                "R9 stall hold", int'(out_energy), h_e);
        end
        hold_pend = out_valid && !out_ready;
        h_id = int'(out_crystal); h_e = int'(out_energy); h_acc = int'(out_accept);
        if (out_valid && out_ready) begin
            if (q_id.size() == 0) begin
                chk(0, "R9 unexpected record", int'(out_energy), -1);
            end else begin
                int xi, xe, xa, xc;
                xi = q_id.pop_front(); xe = q_e.pop_front(); xa = q_acc.pop_front(); xc = q_cyc.pop_front();
                chk(int'(out_energy) == xe, "R1 energy", int'(out_energy), xe);
                chk(int'(out_crystal) == xi, "R3 crystal", int'(out_crystal), xi);
                chk(int'(out_accept) == xa, "R4/R5 accept", int'(out_accept), xa);
                if (lat_on) chk(cyc - xc == LAT, "R7 latency", cyc - xc, LAT);
            end
        end
        took = v && in_ready;
        if (took) begin
            model(a, b, c, d, id, e, acc);
            q_id.push_back(id); q_e.push_back(e); q_acc.push_back(acc); q_cyc.push_back(cyc);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < LAT + 4; i++) tick(0, 0, 0, 0, 0, 1);
        chk(q_id.size() == 0, "R9 no lost events", q_id.size(), 0);
    endtask

    task automatic set_win(input int id, input int lo, input int hi);
        @(negedge clk);
        win_we = 1; win_crystal = ID_W'(id); win_lo = E_W'(lo); win_hi = E_W'(hi);
        @(negedge clk);
        win_we = 0;
        lo_m[id] = lo; hi_m[id] = hi;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int id, e, acc, cnt;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(!out_valid, "R10 out_valid after reset", int'(out_valid), 0);
        chk(in_ready, "R10 in_ready after reset", int'(in_ready), 1);

        // Load the crystal map
        for (int i = 0; i < NMAP; i++) begin
            map_m[i] = (i * 37 + 11) % 144;
            @(negedge clk);
            map_we = 1; map_addr = (2*Q_W)'(i); map_id = ID_W'(map_m[i]);
        end
        @(negedge clk);
        map_we = 0;
        // Load windows
        for (int i = 0; i < NWIN; i++) begin
            if (i < 144) set_win(i, 300 + i * 5, 1800 + i * 5);
            else         set_win(i, 1, 0);
        end

        // Directed corners with ready high: latency checked on every record
        lat_on = 1;
        tick(1, 0, 0, 0, 0, 1);           // R6 zero energy
        tick(1, 100, 50, 0, 0, 1);        // R2 Y ratio of 1.0 saturates
        tick(1, 0, 60, 0, 90, 1);         // R2 X ratio of 1.0 saturates
        tick(1, 1023, 1023, 1023, 1023, 1); // R1 full-scale sum
        tick(1, 1, 0, 0, 0, 1);           // R2 single-count event
        drain();

        // Window boundaries on a fixed event (E = 1000)
        model(400, 300, 200, 100, id, e, acc);
        set_win(id, 1000, 1000);
        tick(1, 400, 300, 200, 100, 1);   // R4 both bounds inclusive -> accept
        drain();
        set_win(id, 1001, 2000);
        tick(1, 400, 300, 200, 100, 1);   // R5 below window -> record, reject
        drain();
        set_win(id, 0, 999);
        tick(1, 400, 300, 200, 100, 1);   // R5 above window -> record, reject
        drain();
        set_win(id, 0, 1000);
        tick(1, 400, 300, 200, 100, 1);   // R4 upper bound inclusive
        drain();

        // R8 throughput: back-to-back burst with ready high
        cnt = 0;
        for (int i = 0; i < 64; i++) begin
            tick(1, $urandom % 1024, $urandom % 1024, $urandom % 1024, $urandom % 1024, 1);
            if (took) cnt++;
        end
        chk(cnt == 64, "R8 one event per clock", cnt, 64);
        drain();

        // Random traffic with backpressure
        lat_on = 0;
        for (int i = 0; i < 3000; i++) begin
            int a, b, c, d, mode;
            mode = $urandom % 8;
            a = $urandom % 1024; b = $urandom % 1024; c = $urandom % 1024; d = $urandom % 1024;
            if (mode == 0) begin a = a % 8; b = b % 8; c = c % 8; d = d % 8; end
            else if (mode == 1) begin c = 0; d = 0; end
            else if (mode == 2) begin a = 0; c = 0; end
            else if (mode == 3) begin b = b % 16; c = c % 16; d = d % 16; end
            tick(($urandom % 4) != 0, a, b, c, d, ($urandom % 3) != 0);
        end
        for (int i = 0; i < 200 && q_id.size() != 0; i++) tick(0, 0, 0, 0, 0, ($urandom % 2) != 0);
        drain();

        done = 1;
        summary();
        $finish;
    end

endmodule